// File: doc/BRIEF.md
# Deep Idle Ratio and Voltage Sequencer

This block moves a multi-core processor model into and out of a deep idle state. It watches one halt flag per core and a feature enable bit. While any core is still running, or the feature is off, the sequencer stays in its run state. In that state the core clock ratio and voltage identifier outputs follow the live operating-point codes with one register stage of delay. A halted core on its own changes nothing.

When every core is halted and the feature is enabled, the sequencer saves the current operating point and drops the clock ratio to a low code. It then waits for a settle pulse, drops the voltage code, and waits for a second settle pulse before it reports the deep idle state. A wake event reverses the steps in the opposite order. The voltage goes back to its saved value first, and the ratio is restored only after that step has settled. A wake event that arrives part way through entry is held until the current step settles, and then the exit begins.

The bus clock is never touched. Only the internal ratio code is stepped. Snoop requests are acknowledged in every state, including deep idle. Generating the real clock and regulating the real voltage are left to other blocks.

Top module: `idle_vr_sequencer`

## Requirements
- R1: After reset, ratio_code and vid_code are 0, and busy, in_deep and snoop_ack are 0.
- R2: While in the run state without entry (not every core_halt bit set, or deep_en low), ratio_code and vid_code equal run_ratio and run_vid as sampled at the previous clock edge, and busy stays 0.
- R3: At the first edge where all core_halt bits are 1, deep_en is 1 and wake_evt is 0, ratio_code becomes LOW_RATIO, vid_code keeps its value and busy becomes 1.
- R4: During any busy step, both codes hold until settle_done is seen at an edge. The voltage code drops to LOW_VID only at the edge where the ratio step settles.
- R5: At the edge where the voltage-down step settles (with no wake pending), in_deep becomes 1 and busy becomes 0, with the codes at LOW_RATIO and LOW_VID.
- R6: In deep idle, only wake_evt leads out. Changes to core_halt, deep_en, run_ratio, run_vid or settle_done leave in_deep and both codes unchanged.
- R7: On exit, vid_code returns to its saved value while ratio_code stays low. After the next settle_done, ratio_code returns to its saved value. After one more settle_done, busy falls to 0 in the run state.
- R8: The values restored on exit are the codes that were on the outputs at entry, even if run_ratio and run_vid changed in between.
- R9: A wake_evt during an entry step is held until that step settles. During the ratio step, the exit goes straight to restoring the ratio (the voltage was never lowered). During the voltage step, the exit restores the voltage and then the ratio.
- R10: busy is 1 in every stepping state, and ratio_code and vid_code never change at the same edge while busy.
- R11: snoop_ack is 1 in the cycle after snoop_req is 1 and 0 in the cycle after it is 0, in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_halt | input | NUM_CORES | Per-core halted flag |
| deep_en | input | 1 | Feature enable for deep idle |
| run_ratio | input | RATIO_W | Live operating ratio code |
| run_vid | input | VID_W | Live operating voltage code |
| settle_done | input | 1 | One-cycle pulse: current step has settled |
| wake_evt | input | 1 | Break event |
| snoop_req | input | 1 | Snoop request |
| ratio_code | output | RATIO_W | Ratio code in force |
| vid_code | output | VID_W | Voltage code in force |
| in_deep | output | 1 | Deep idle state reached |
| busy | output | 1 | A ratio or voltage step is in progress |
| snoop_ack | output | 1 | Snoop flagged as serviced |

## Verification
Every result is one register stage from its cause. A code change, a busy or in_deep change, and snoop_ack all appear right after the edge that samples the entry condition, the settle pulse or the wake pulse. The bench drives each input a little after a rising edge and checks the outputs a little after the next one, so each check falls in the cycle where the result first shows. Stretches with no settle pulse are checked on several edges in a row, to show that nothing advances early. A negative-edge monitor compares every busy edge against the one before it, to catch both codes moving together.

// File: rtl/idle_seq_pkg.sv
package idle_seq_pkg;
   typedef enum logic [2:0] {
      ST_RUN      = 3'd0,
      ST_DN_RATIO = 3'd1,
      ST_DN_VID   = 3'd2,
      ST_DEEP     = 3'd3,
      ST_UP_VID   = 3'd4,
      ST_UP_RATIO = 3'd5
   } seq_state_t;

   function automatic logic is_step(seq_state_t s);
      return (s == ST_DN_RATIO) || (s == ST_DN_VID) ||
             (s == ST_UP_VID)   || (s == ST_UP_RATIO);
   endfunction
endpackage

// File: rtl/idle_seq_gate.sv
module idle_seq_gate #(
   parameter int NUM_CORES = 2
) (
   input  logic [NUM_CORES-1:0] core_halt,
   input  logic                 deep_en,
   input  logic                 wake_evt,
   output logic                 enter_ok
);
   logic [NUM_CORES:0] chain;

   assign chain[0] = 1'b1;
   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      assign chain[c+1] = chain[c] & core_halt[c];
   end

   assign enter_ok = chain[NUM_CORES] & deep_en & ~wake_evt;
endmodule

// File: rtl/idle_seq_code.sv
module idle_seq_code #(
   parameter int W   = 6,
   parameter int LOW = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] live,
   input  logic         track,
   input  logic         capture,
   input  logic         go_low,
   input  logic         go_saved,
   output logic [W-1:0] code
);
   localparam logic [W-1:0] LOW_CODE = W'(LOW);
   logic [W-1:0] saved_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code    <= '0;
         saved_q <= '0;
      end else begin
         if (capture) saved_q <= code;
         if (track)         code <= live;
         else if (go_low)   code <= LOW_CODE;
         else if (go_saved) code <= saved_q;
      end
   end
endmodule

// File: rtl/idle_seq_ctrl.sv
module idle_seq_ctrl
   import idle_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enter_ok,
   input  logic       settle_done,
   input  logic       wake_evt,
   output seq_state_t state_q,
   output logic       track,
   output logic       capture,
   output logic       r_low,
   output logic       r_rest,
   output logic       v_low,
   output logic       v_rest
);
   seq_state_t nxt;
   logic       pend_q, pend;

   assign pend = pend_q | wake_evt;

   always_comb begin
      nxt     = state_q;
      track   = 1'b0;
      capture = 1'b0;
      r_low   = 1'b0;
      r_rest  = 1'b0;
      v_low   = 1'b0;
      v_rest  = 1'b0;
      unique case (state_q)
         ST_RUN: begin
            if (enter_ok) begin
               nxt     = ST_DN_RATIO;
               capture = 1'b1;
               r_low   = 1'b1;
            end else begin
               track = 1'b1;
            end
         end
         ST_DN_RATIO: if (settle_done) begin
            if (pend) begin
               nxt    = ST_UP_RATIO;
               r_rest = 1'b1;
            end else begin
               nxt   = ST_DN_VID;
               v_low = 1'b1;
            end
         end
         ST_DN_VID: if (settle_done) begin
            if (pend) begin
               nxt    = ST_UP_VID;
               v_rest = 1'b1;
            end else begin
               nxt = ST_DEEP;
            end
         end
         ST_DEEP: if (wake_evt) begin
            nxt    = ST_UP_VID;
            v_rest = 1'b1;
         end
         ST_UP_VID: if (settle_done) begin
            nxt    = ST_UP_RATIO;
            r_rest = 1'b1;
         end
         ST_UP_RATIO: if (settle_done) nxt = ST_RUN;
         default: nxt = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         pend_q  <= 1'b0;
      end else begin
         state_q <= nxt;
         pend_q  <= ((nxt == ST_DN_RATIO) || (nxt == ST_DN_VID)) ? pend : 1'b0;
      end
   end

   // R6: deep idle is left only on a wake event
   a_r6_deep_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DEEP && !wake_evt) |=> (state_q == ST_DEEP));

   // R9: a held wake never lets entry reach deep idle
   a_r9_no_deep_with_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DN_VID && wake_evt) |=> (state_q != ST_DEEP));
endmodule

// File: rtl/idle_vr_sequencer.sv
module idle_vr_sequencer
   import idle_seq_pkg::*;
#(
   parameter int NUM_CORES = 2,
   parameter int RATIO_W   = 6,
   parameter int VID_W     = 7,
   parameter int LOW_RATIO = 6,
   parameter int LOW_VID   = 20,
   parameter bit SNOOP_REG = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CORES-1:0] core_halt,
   input  logic                 deep_en,
   input  logic [RATIO_W-1:0]   run_ratio,
   input  logic [VID_W-1:0]     run_vid,
   input  logic                 settle_done,
   input  logic                 wake_evt,
   input  logic                 snoop_req,
   output logic [RATIO_W-1:0]   ratio_code,
   output logic [VID_W-1:0]     vid_code,
   output logic                 in_deep,
   output logic                 busy,
   output logic                 snoop_ack
);
   localparam int RATIO_MAX = (1 << RATIO_W) - 1;
   localparam int VID_MAX   = (1 << VID_W) - 1;

   if (NUM_CORES < 1) begin : g_bad_cores
      $error("NUM_CORES must be at least 1");
   end
   if (LOW_RATIO < 0 || LOW_RATIO > RATIO_MAX) begin : g_bad_ratio
      $error("LOW_RATIO does not fit RATIO_W");
   end
   if (LOW_VID < 0 || LOW_VID > VID_MAX) begin : g_bad_vid
      $error("LOW_VID does not fit VID_W");
   end

   seq_state_t state_q;
   logic enter_ok, track, capture, r_low, r_rest, v_low, v_rest;

   idle_seq_gate #(.NUM_CORES(NUM_CORES)) i_gate (
      .core_halt(core_halt), .deep_en(deep_en), .wake_evt(wake_evt),
      .enter_ok(enter_ok));

   idle_seq_ctrl i_ctrl (
      .clk(clk), .rst_n(rst_n), .enter_ok(enter_ok),
      .settle_done(settle_done), .wake_evt(wake_evt), .state_q(state_q),
      .track(track), .capture(capture), .r_low(r_low), .r_rest(r_rest),
      .v_low(v_low), .v_rest(v_rest));

   idle_seq_code #(.W(RATIO_W), .LOW(LOW_RATIO)) i_ratio (
      .clk(clk), .rst_n(rst_n), .live(run_ratio), .track(track),
      .capture(capture), .go_low(r_low), .go_saved(r_rest),
      .code(ratio_code));

   idle_seq_code #(.W(VID_W), .LOW(LOW_VID)) i_vid (
      .clk(clk), .rst_n(rst_n), .live(run_vid), .track(track),
      .capture(capture), .go_low(v_low), .go_saved(v_rest),
      .code(vid_code));

   assign busy    = is_step(state_q);
   assign in_deep = (state_q == ST_DEEP);

   if (SNOOP_REG) begin : g_snoop_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) snoop_ack <= 1'b0;
         else        snoop_ack <= snoop_req;
      end
      // R11: each snoop is flagged one cycle later, in any state
      a_r11_snoop_ack: assert property (@(posedge clk) disable iff (!rst_n)
         snoop_req |=> snoop_ack);
   end else begin : g_snoop_comb
      assign snoop_ack = snoop_req;
   end

   // R3: entry lowers the ratio first, voltage untouched
   a_r3_ratio_first: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && enter_ok) |=> (busy && vid_code == $past(vid_code)));

   // R4: no step advances without a settle pulse
   a_r4_hold_unsettled: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !settle_done) |=> ($stable(ratio_code) && $stable(vid_code)));

   // R7: exit moves the voltage first, ratio held
   a_r7_vid_first: assert property (@(posedge clk) disable iff (!rst_n)
      (in_deep && wake_evt) |=> (busy && ratio_code == $past(ratio_code)));

   // R10: never both codes on one edge while sequencing
   a_r10_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !((ratio_code != $past(ratio_code)) && (vid_code != $past(vid_code))));
endmodule

// File: tb/test_idle_vr_sequencer.sv
module test_idle_vr_sequencer;
   localparam int CLK_PERIOD = 10;
   localparam int RW = 6;
   localparam int VW = 7;
   localparam int LR = 6;
   localparam int LV = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] core_halt = '0;
   logic deep_en = 1'b0;
   logic [RW-1:0] run_ratio = '0;
   logic [VW-1:0] run_vid = '0;
   logic settle_done = 1'b0, wake_evt = 1'b0, snoop_req = 1'b0;
   logic [RW-1:0] ratio_code;
   logic [VW-1:0] vid_code;
   logic in_deep, busy, snoop_ack;

   int checks = 0;
   int fails  = 0;
   int dbl    = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   idle_vr_sequencer #(.NUM_CORES(2), .RATIO_W(RW), .VID_W(VW),
      .LOW_RATIO(LR), .LOW_VID(LV)) i_idle_vr_sequencer (
      .clk(clk), .rst_n(rst_n), .core_halt(core_halt), .deep_en(deep_en),
      .run_ratio(run_ratio), .run_vid(run_vid), .settle_done(settle_done),
      .wake_evt(wake_evt), .snoop_req(snoop_req), .ratio_code(ratio_code),
      .vid_code(vid_code), .in_deep(in_deep), .busy(busy),
      .snoop_ack(snoop_ack));

   // R10 monitor: both codes moving across one busy edge
   logic [RW-1:0] pr;
   logic [VW-1:0] pv;
   logic pb = 1'b0;
   always @(negedge clk) begin
      if (rst_n && pb && ratio_code != pr && vid_code != pv) dbl++;
      pr = ratio_code; pv = vid_code; pb = busy & rst_n;
   end

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic settle();
      settle_done = 1'b1; tick(); settle_done = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 ratio", ratio_code, 0);
      chk("R1 vid", vid_code, 0);
      chk("R1 busy", busy, 0);
      chk("R1 in_deep", in_deep, 0);
      chk("R1 snoop_ack", snoop_ack, 0);
   endtask

   task automatic t_partial();
      run_ratio = 20; run_vid = 50; core_halt = 2'b01; deep_en = 1'b1;
      tick();
      chk("R2 ratio tracks", ratio_code, 20);
      chk("R2 vid tracks", vid_code, 50);
      chk("R2 one core halted no busy", busy, 0);
      core_halt = 2'b11; deep_en = 1'b0; run_ratio = 22;
      tick();
      chk("R2 disabled ratio", ratio_code, 22);
      chk("R2 disabled busy", busy, 0);
      chk("R2 disabled in_deep", in_deep, 0);
      core_halt = 2'b00; run_ratio = 20;
      tick();
   endtask

   task automatic t_enter();
      core_halt = 2'b11; deep_en = 1'b1;
      tick();
      chk("R3 ratio low", ratio_code, LR);
      chk("R3 vid kept", vid_code, 50);
      chk("R3 busy", busy, 1);
      tick(); tick();
      chk("R4 ratio step waits vid", vid_code, 50);
      settle();
      chk("R4 vid low after settle", vid_code, LV);
      chk("R10 busy in vid step", busy, 1);
      tick();
      chk("R4 vid step waits", in_deep, 0);
      settle();
      chk("R5 in_deep", in_deep, 1);
      chk("R5 busy low", busy, 0);
      chk("R5 ratio", ratio_code, LR);
      chk("R5 vid", vid_code, LV);
   endtask

   task automatic t_deep_hold();
      core_halt = 2'b00; deep_en = 1'b0; run_ratio = 33; run_vid = 60;
      settle_done = 1'b1; snoop_req = 1'b1;
      tick();
      chk("R11 snoop in deep", snoop_ack, 1);
      settle_done = 1'b0; snoop_req = 1'b0;
      tick(); tick();
      chk("R11 snoop drop", snoop_ack, 0);
      chk("R6 stays deep", in_deep, 1);
      chk("R6 ratio held", ratio_code, LR);
      chk("R6 vid held", vid_code, LV);
   endtask

   task automatic t_exit();
      wake_evt = 1'b1; tick(); wake_evt = 1'b0;
      chk("R7 vid restored first", vid_code, 50);
      chk("R7 ratio still low", ratio_code, LR);
      chk("R7 busy", busy, 1);
      tick();
      chk("R7 ratio waits settle", ratio_code, LR);
      settle();
      chk("R8 ratio restored to saved", ratio_code, 20);
      chk("R8 vid saved", vid_code, 50);
      settle();
      chk("R7 busy cleared", busy, 0);
      chk("R7 not deep", in_deep, 0);
      tick();
      chk("R2 tracks after exit ratio", ratio_code, 33);
      chk("R2 tracks after exit vid", vid_code, 60);
      run_ratio = 20; run_vid = 50;
      tick();
   endtask

   task automatic t_break_ratio();
      core_halt = 2'b11; deep_en = 1'b1;
      tick();
      core_halt = 2'b00;
      wake_evt = 1'b1; tick(); wake_evt = 1'b0;
      chk("R9 ratio step finishes", ratio_code, LR);
      chk("R9 vid untouched", vid_code, 50);
      chk("R9 busy", busy, 1);
      settle();
      chk("R9 ratio restored", ratio_code, 20);
      chk("R9 vid never lowered", vid_code, 50);
      chk("R9 not deep", in_deep, 0);
      settle();
      chk("R9 back to run", busy, 0);
   endtask

   task automatic t_break_vid();
      core_halt = 2'b11; deep_en = 1'b1;
      tick();
      settle();
      core_halt = 2'b00;
      chk("R9 vid step low", vid_code, LV);
      wake_evt = 1'b1; tick(); wake_evt = 1'b0;
      chk("R9 vid step waits", vid_code, LV);
      settle();
      chk("R9 vid restored", vid_code, 50);
      chk("R9 ratio low", ratio_code, LR);
      chk("R9 skipped deep", in_deep, 0);
      settle();
      chk("R9 ratio restored", ratio_code, 20);
      settle();
      chk("R9 run busy", busy, 0);
      snoop_req = 1'b1; tick(); snoop_req = 1'b0;
      chk("R11 snoop in run", snoop_ack, 1);
      chk("R10 no double change", dbl, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 3);
      t_reset();
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      t_partial();
      t_enter();
      t_deep_hold();
      t_exit();
      t_break_ratio();
      t_break_vid();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule